// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

The deframer sits behind a bit-level demodulator and turns a stream of decoded line bits into a byte stream for a receive FIFO. It accepts one bit each time `bit_valid` is high while `bit_ready` is high. Every accepted bit goes into an 8-bit history window. That window is used to recognise frame flags, abort runs and stuffed zeros. Bits that survive these checks are packed into bytes, least significant bit first.

Frame delimiters are passed on in-band: each flag that is seen while the FIFO has room is written to the FIFO as the flag byte. Data bytes that would be confused with a control value are preceded by an escape byte. The escape and the data byte go out on two consecutive cycles, and the bit input is held off with `bit_ready` low for one cycle between them. A FIFO that is full when a write is due drops the frame and returns the block to hunting. CRC checking and interpretation of frame contents are left to the consumer.

The controller has three states:
- `RX_HUNT`: disarmed, bits are ignored.
- `RX_FRAME`: armed, bytes are being assembled.
- `RX_ESC_PEND`: an escape byte has been written and the data byte is still due.

Transitions:
- hunt→frame: a flag arrives and the FIFO has room.
- frame→hunt: an abort run, a flag that arrives while the FIFO is full, or a full FIFO when a byte is due.
- frame→frame: a flag that arrives while the FIFO has room re-arms and resets the byte builder.
- frame→esc_pend: a completed byte needs an escape.
- esc_pend→frame: the data byte is written.
- esc_pend→hunt: the FIFO is full when the data byte is due.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While `rst_n` is low, `push` is 0 and `bit_ready` is 1. After reset the block is disarmed, the history is all zeros and the bit count is zero.
- R2: When the 8-bit history, after the new bit is shifted in at bit 0, equals 8'h7E and `fifo_full` is 0, the block pushes 8'h7E in that same cycle and arms. Any flag clears the bit count.
- R3: When a flag is recognised while `fifo_full` is 1, nothing is pushed and the block disarms.
- R4: When the low seven history bits are all 1 (and the history is not a flag), the block disarms.
- R5: While disarmed, accepted bits push nothing except a flag. They still enter the history.
- R6: While armed, a bit that makes the low six history bits equal 6'b111110 is discarded and does not count toward a byte.
- R7: While armed, the other bits are packed into a byte. Each new bit enters at bit 7 and earlier bits move toward bit 0. On the eighth such bit the byte is pushed in that cycle if `fifo_full` is 0, and the count restarts.
- R8: A completed byte equal to 8'h7E, 8'h7F or 8'h1B is handled in two steps. In the cycle it completes, 8'h1B is pushed. In the next cycle the byte itself is pushed. During that next cycle `bit_ready` is 0.
- R9: If `fifo_full` is 1 in a cycle where a data byte or an escape byte is due, nothing is pushed and the block disarms.
- R10: At most one byte is pushed per cycle, and `push` is never high while `fifo_full` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A decoded bit is offered |
| bit_in | input | 1 | Decoded bit value |
| bit_ready | output | 1 | Block can take a bit this cycle |
| fifo_full | input | 1 | Receive FIFO cannot take a byte |
| push | output | 1 | Write `push_byte` into the FIFO this cycle |
| push_byte | output | 8 | Byte to write |

## Verification
The hardest case to reach from the ports is a full FIFO that appears exactly in the cycle after an escape byte was written. The escaped data byte is then still pending, so this is a narrow window. Bits are fed as byte-level frames, with stuffing added by the bench. The payloads are biased toward 8'h7E, 8'h7F and 8'h1B, and the FIFO full flag is driven at varying random densities, so that this window and the escape-time full case both occur many times. Abort runs and raw noise between frames drive the disarm paths. Noise also produces stray flags that must be picked up again from the hunt state.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    typedef enum logic [1:0] {
        RX_HUNT     = 2'd0,
        RX_FRAME    = 2'd1,
        RX_ESC_PEND = 2'd2
    } rx_state_e;
endpackage

// File: rtl/hdlc_rx_hist.sv
// Sliding window of the most recent line bits with pattern classification
// performed on the window as it will look after the current bit.
module hdlc_rx_hist #(
    parameter int          W         = 8,
    parameter logic [W-1:0] FLAG_VAL  = 8'h7E,
    parameter logic [W-1:0] ABORT_VAL = 8'h7F,
    parameter int          RUN_LEN   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic is_flag,
    output logic is_abort,
    output logic is_stuff
);
    localparam int STUFF_W = RUN_LEN + 1;
    localparam logic [STUFF_W-1:0] STUFF_PAT = {{RUN_LEN{1'b1}}, 1'b0};

    logic [W-1:0] win_q;
    logic [W-1:0] win_nx;

    assign win_nx   = {win_q[W-2:0], bit_in};
    assign is_flag  = (win_nx == FLAG_VAL);
    assign is_abort = ((win_nx & ABORT_VAL) == ABORT_VAL);
    assign is_stuff = (win_nx[STUFF_W-1:0] == STUFF_PAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= win_nx;
        end
    end
endmodule

// File: rtl/hdlc_rx_byte.sv
// LSB-first byte builder with a bit counter.
module hdlc_rx_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] byte_nx,
    output logic         last_bit
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  acc_q;
    logic [CW-1:0] cnt_q;

    assign byte_nx  = {bit_in, acc_q[W-1:1]};
    assign last_bit = (cnt_q == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            acc_q <= byte_nx;
            cnt_q <= last_bit ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
    parameter int          W       = 8,
    parameter logic [W-1:0] FLAG    = 8'h7E,
    parameter logic [W-1:0] ABORT   = 8'h7F,
    parameter logic [W-1:0] ESC     = 8'h1B,
    parameter int          RUN_LEN = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic         bit_ready,
    input  logic         fifo_full,
    output logic         push,
    output logic [W-1:0] push_byte
);
    import hdlc_rx_pkg::*;

    rx_state_e    state_q, state_d;
    logic         take;
    logic         is_flag, is_abort, is_stuff;
    logic         pack_en, last_bit, completed, special;
    logic [W-1:0] byte_nx;
    logic [W-1:0] pend_q;

    assign bit_ready = (state_q != RX_ESC_PEND);
    assign take      = bit_valid && bit_ready;

    hdlc_rx_hist #(
        .W(W), .FLAG_VAL(FLAG), .ABORT_VAL(ABORT), .RUN_LEN(RUN_LEN)
    ) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(take), .bit_in(bit_in),
        .is_flag(is_flag), .is_abort(is_abort), .is_stuff(is_stuff)
    );

    assign pack_en = take && (state_q == RX_FRAME) && !is_flag && !is_abort && !is_stuff;

    hdlc_rx_byte #(.W(W)) u_byte (
        .clk(clk), .rst_n(rst_n), .clear(take && is_flag),
        .shift_en(pack_en), .bit_in(bit_in),
        .byte_nx(byte_nx), .last_bit(last_bit)
    );

    assign completed = pack_en && last_bit;
    assign special   = (byte_nx == FLAG) || (byte_nx == ABORT) || (byte_nx == ESC);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (completed && special) begin
            pend_q <= byte_nx;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: begin
                if (take && is_flag && !fifo_full) state_d = RX_FRAME;
            end
            RX_FRAME: begin
                if (take) begin
                    if (is_flag) begin
                        state_d = fifo_full ? RX_HUNT : RX_FRAME;
                    end else if (is_abort) begin
                        state_d = RX_HUNT;
                    end else if (completed) begin
                        if (fifo_full)    state_d = RX_HUNT;
                        else if (special) state_d = RX_ESC_PEND;
                    end
                end
            end
            RX_ESC_PEND: begin
                state_d = fifo_full ? RX_HUNT : RX_FRAME;
            end
            default: state_d = RX_HUNT;
        endcase
    end

    // Outputs
    always_comb begin
        push      = 1'b0;
        push_byte = FLAG;
        unique case (state_q)
            RX_HUNT, RX_FRAME: begin
                if (take && is_flag) begin
                    push      = !fifo_full;
                    push_byte = FLAG;
                end else if (completed) begin
                    push      = !fifo_full;
                    push_byte = special ? ESC : byte_nx;
                end
            end
            RX_ESC_PEND: begin
                push      = !fifo_full;
                push_byte = pend_q;
            end
            default: push = 1'b0;
        endcase
    end
endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker #(
    parameter int          W    = 8,
    parameter logic [W-1:0] FLAG = 8'h7E,
    parameter logic [W-1:0] ESC  = 8'h1B
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bit_ready,
    input logic                   fifo_full,
    input logic                   push,
    input logic [W-1:0]           push_byte,
    input hdlc_rx_pkg::rx_state_e state
);
    import hdlc_rx_pkg::*;

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!push && bit_ready);
        end
    end

    // R10
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);

    // R8
    esc_stalls_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && bit_ready && push_byte == ESC && state == RX_FRAME) |=> !bit_ready);

    // R8
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_ready |=> bit_ready);

    // R5
    hunt_only_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && state == RX_HUNT) |-> (push_byte == FLAG));

    // R9
    full_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_ready && fifo_full) |=> (state == RX_HUNT));
endmodule

bind hdlc_rx_deframer hdlc_rx_checker #(.W(W), .FLAG(FLAG), .ESC(ESC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_ready(bit_ready), .fifo_full(fifo_full),
    .push(push), .push_byte(push_byte), .state(state_q)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       fifo_full = 1'b0;
    logic       bit_ready;
    logic       push;
    logic [7:0] push_byte;

    always #5 clk = ~clk;

    hdlc_rx_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .bit_ready(bit_ready), .fifo_full(fifo_full),
        .push(push), .push_byte(push_byte)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit bitq[$];
    int ones_run;

    // reference state: 0 hunt, 1 frame, 2 pending data after escape
    int m_hist, m_st, m_cnt, m_byte, m_pend;

    task automatic put_flag();
        for (int i = 0; i < 8; i++) bitq.push_back(((8'h7E >> i) & 1) != 0);
        ones_run = 0;
    endtask

    task automatic put_byte(input int b);
        for (int i = 0; i < 8; i++) begin
            bit v = ((b >> i) & 1) != 0;
            bitq.push_back(v);
            if (v) begin
                ones_run++;
                if (ones_run == 5) begin bitq.push_back(1'b0); ones_run = 0; end
            end else ones_run = 0;
        end
    endtask

    function automatic int pick_byte();
        int r = $urandom % 10;
        if (r == 0) return 8'h7E;
        if (r == 1) return 8'h7F;
        if (r == 2) return 8'h1B;
        if (r == 3) return 8'hFF;
        return $urandom % 256;
    endfunction

    task automatic check(input string tag, input bit ep, input int eb, input bit er);
        n_cmp++;
        if (push !== ep || bit_ready !== er || (ep && push_byte !== eb[7:0])) begin
            n_bad++;
            $display("FAIL %s: push=%0b byte=%02h ready=%0b expected push=%0b byte=%02h ready=%0b",
                     tag, push, push_byte, bit_ready, ep, eb[7:0], er);
        end
    endtask

    task automatic step(input int full_pct);
        bit  v, b, f, ep, er, tk;
        int  eb, ns, h;
        string tag;
        @(negedge clk);
        v = ($urandom % 100) < 85;
        b = (bitq.size() > 0) ? bitq[0] : 1'b0;
        f = ($urandom % 100) < full_pct;
        bit_valid = v; bit_in = b; fifo_full = f;
        #1;
        er = (m_st != 2);
        tk = v && er;
        ep = 0; eb = 0; ns = m_st; tag = "R5";
        if (m_st == 2) begin
            ep = !f; eb = m_pend; ns = f ? 0 : 1; tag = f ? "R9" : "R8";
        end else if (tk) begin
            h = (m_hist * 2 + b) % 256;
            m_hist = h;
            if (h == 126) begin
                m_cnt = 0; m_byte = 0;
                if (!f) begin ep = 1; eb = 126; ns = 1; tag = "R2"; end
                else begin ns = 0; tag = "R3"; end
            end else if (h % 128 == 127) begin
                ns = 0; tag = "R4";
            end else if (m_st == 0) begin
                tag = "R5";
            end else if (h % 64 == 62) begin
                tag = "R6";
            end else begin
                m_byte = m_byte / 2 + b * 128;
                m_cnt++;
                tag = "R7";
                if (m_cnt == 8) begin
                    m_cnt = 0;
                    if (f) begin ns = 0; tag = "R9"; end
                    else if (m_byte == 126 || m_byte == 127 || m_byte == 27) begin
                        ep = 1; eb = 27; ns = 2; m_pend = m_byte; tag = "R8";
                    end else begin
                        ep = 1; eb = m_byte;
                    end
                end
            end
        end
        check(tag, ep, eb, er);
        if (tk && bitq.size() > 0) void'(bitq.pop_front());
        m_st = ns;
    endtask

    initial begin
        int pct;
        m_hist = 0; m_st = 0; m_cnt = 0; m_byte = 0; m_pend = 0; ones_run = 0;
        repeat (3) begin
            @(negedge clk); #1;
            check("R1", 1'b0, 0, 1'b1);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int fr = 0; fr < 160; fr++) begin
            int nb = 1 + ($urandom % 12);
            for (int k = 0; k < ($urandom % 6); k++) bitq.push_back($urandom % 2);
            put_flag();
            if (fr % 3 == 0) put_flag();
            for (int k = 0; k < nb; k++) put_byte(pick_byte());
            if (fr % 7 == 3) for (int k = 0; k < 9; k++) bitq.push_back(1'b1);
            put_flag();
            pct = (fr % 4 == 0) ? 0 : (fr % 4 == 1) ? 8 : (fr % 4 == 2) ? 30 : 60;
            while (bitq.size() > 0) step(pct);
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule